// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block walks a PCIe port from a cold, unpowered slot to a trained link without firmware involvement. One start pulse launches a fixed chain. The slot is held in reset while its power is switched on. The controller leaves its power-up reset while the PHY is still held, so the PHY's lane registers can be programmed by a separate handshake block. The auxiliary clock is cycled off and on around the release of the PHY hold. The controller is then told whether it is a root complex or an endpoint, and the sequencer reads that value back to confirm it.

If the link is not already up, the sequencer raises the low nibble of the link capability word. That register is read-only under normal conditions, so the write goes through a temporary write-enable window. The sequencer then enables the link training state machine and polls a status word until the link is trained or the poll budget runs out.

All waits count pulses on a millisecond tick input, so an integrator can feed any slower or faster tick. Control and status registers are reached through a simple request/acknowledge register port with one access outstanding. The outcome is reported as a 2-bit result code together with a one-cycle done pulse.

Top module: `pcie_port_bringup`

## Requirements
- R1: Out of reset, every drive output is off: slot_rst_no=0, pwr_en_o=0, aux_clk_en_o=0, ctrl_rst_no=0, phy_hold_rst_o=0, ltssm_en_o=0. In addition busy_o=0, done_o=0 and reg_req_o=0.
- R2: A start pulse while idle sets busy_o, drives the slot reset low and turns power off. After RST_WAIT_MS ticks (default 100) pwr_en_o rises. After another RST_WAIT_MS ticks slot_rst_no rises. After a third RST_WAIT_MS ticks aux_clk_en_o rises.
- R3: phy_hold_rst_o rises one cycle after the aux clock enable. ctrl_rst_no rises one cycle after that. In the same cycle phy_prog_start_o pulses for one cycle, and the sequencer waits for phy_prog_done_i.
- R4: The cycle after phy_prog_done_i is seen, aux_clk_en_o falls. One cycle later phy_hold_rst_o falls. One cycle later aux_clk_en_o rises again.
- R5: The device-type register at address 0x708 is written with 0x4 when mode_rc_i was 1 at start, or 0x0 otherwise, and then read back. If the read value differs, the run ends with result 2, the LTSSM is never enabled and no further write is made.
- R6: The link counts as up only when link_status_i bit 4 is 1 and bit 29 is 0. If the link is up right after the read-back, the run ends with result 1, with no speed-cap access and ltssm_en_o left at 0.
- R7: The speed cap is raised in this order: read misc control (0x8BC), write it with bit 0 set, read link capability (0x07C), write it with bits 3:0 set and its other bits unchanged, then write misc control with bit 0 cleared and its other bits unchanged. All of this happens before ltssm_en_o rises.
- R8: ltssm_en_o then rises. After TRAIN_WAIT_MS ticks (default 20) the link is tested on each tick, up to POLL_MAX tests (default 20). The first passing test ends the run with result 0.
- R9: If all POLL_MAX tests fail, phy_hold_rst_o is asserted again and the run ends with result 3. That is exactly TRAIN_WAIT_MS+POLL_MAX ticks after ltssm_en_o rises.
- R10: done_o is a one-cycle pulse in the cycle busy_o falls. result_o holds its value until the next start.
- R11: A start pulse while busy_o is high is ignored.
- R12: Once reg_req_o is raised, it stays high with reg_we_o, reg_addr_o and reg_wdata_o stable until reg_ack_i is seen. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| mode_rc_i | input | 1 | 1 selects root complex, 0 endpoint; sampled at start |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| slot_rst_no | output | 1 | Slot reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| ctrl_rst_no | output | 1 | Controller power-up reset, active low |
| phy_hold_rst_o | output | 1 | Holds PHY and LTSSM in reset |
| ltssm_en_o | output | 1 | Link training enable |
| phy_prog_start_o | output | 1 | One-cycle request to the PHY programming block |
| phy_prog_done_i | input | 1 | PHY programming finished |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_ack_i | input | 1 | Access complete |
| reg_rdata_i | input | DATA_W | Read data, valid with reg_ack_i |
| link_status_i | input | DATA_W | Link status word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 already up, 2 mode mismatch, 3 timeout |

## Verification
The bench builds the block with its default parameters: 100-tick reset waits, a 20-tick training wait, 20 polls and the register addresses above. It drives a tick every fourth clock, so each run takes about 1,400 cycles, and every wait can be checked as an exact count of ticks rather than a cycle window. A register model with a write-protected capability register and a stalling acknowledge covers several cases at once. The stall exposes request stability. The write protection lets the final capability value prove that the write window was open. The register model and the status stimulus also reach the mismatch, already-up, never-up and still-training outcomes.

// File: rtl/bup_pkg.sv
package bup_pkg;
  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_ALREADY  = 2'd1,
    RES_MISMATCH = 2'd2,
    RES_TIMEOUT  = 2'd3
  } bup_res_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_W_SLOT, ST_W_PWR, ST_W_REL, ST_HOLD, ST_CTRL, ST_PROG,
    ST_HOLD_REL, ST_AUX_ON, ST_DT_WR, ST_DT_RD, ST_LNK0, ST_MISC_RD,
    ST_MISC_SET, ST_CAP_RD, ST_CAP_WR, ST_MISC_CLR, ST_LTSSM, ST_W_TRAIN,
    ST_POLL
  } bup_state_e;
endpackage

// File: rtl/bup_tick_timer.sv
module bup_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/bup_reg_port.sv
module bup_reg_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              req_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_q) begin
        if (ack_i) begin
          req_q   <= 1'b0;
          rdata_q <= rdata_i;
          done_q  <= 1'b1;
        end
      end else if (go_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/bup_link_eval.sv
module bup_link_eval #(
  parameter int DATA_W    = 32,
  parameter int UP_BIT    = 4,
  parameter int TRAIN_BIT = 29
) (
  input  logic [DATA_W-1:0] status_i,
  output logic              up_o
);
  localparam logic [DATA_W-1:0] UP_MASK  = DATA_W'(1) << UP_BIT;
  localparam logic [DATA_W-1:0] TRN_MASK = DATA_W'(1) << TRAIN_BIT;

  // trained means up and no longer in training
  assign up_o = ((status_i & UP_MASK) != '0) && ((status_i & TRN_MASK) == '0);
endmodule

// File: rtl/pcie_port_bringup.sv
module pcie_port_bringup
  import bup_pkg::*;
#(
  parameter int              ADDR_W        = 12,
  parameter int              DATA_W        = 32,
  parameter int              RST_WAIT_MS   = 100,
  parameter int              TRAIN_WAIT_MS = 20,
  parameter int              POLL_MAX      = 20,
  parameter logic [11:0]     DEVTYPE_ADDR  = 12'h708,
  parameter logic [11:0]     MISC_ADDR     = 12'h8BC,
  parameter logic [11:0]     LINKCAP_ADDR  = 12'h07C,
  parameter int              RC_CODE       = 4,
  parameter int              EP_CODE       = 0,
  parameter int              RO_WR_BIT     = 0,
  parameter int              SPEED_W       = 4,
  parameter int              UP_BIT        = 4,
  parameter int              TRAIN_BIT     = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_rc_i,
  input  logic              ms_tick_i,
  output logic              slot_rst_no,
  output logic              pwr_en_o,
  output logic              aux_clk_en_o,
  output logic              ctrl_rst_no,
  output logic              phy_hold_rst_o,
  output logic              ltssm_en_o,
  output logic              phy_prog_start_o,
  input  logic              phy_prog_done_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic [DATA_W-1:0] link_status_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  localparam int TMR_MAX = (RST_WAIT_MS > TRAIN_WAIT_MS) ? RST_WAIT_MS : TRAIN_WAIT_MS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam logic [DATA_W-1:0] RO_MASK    = DATA_W'(1) << RO_WR_BIT;
  localparam logic [DATA_W-1:0] SPEED_MASK = DATA_W'((64'd1 << SPEED_W) - 64'd1);
  localparam logic [DATA_W-1:0] DT_RC      = DATA_W'(RC_CODE);
  localparam logic [DATA_W-1:0] DT_EP      = DATA_W'(EP_CODE);

  bup_state_e         state_q;
  logic               slot_q, pwr_q, aux_q, ctrl_q, hold_q, ltssm_q, pstart_q;
  logic               busy_q, done_q, mode_q, pend_q;
  bup_res_e           res_q;
  logic [DATA_W-1:0]  misc_q, cap_q;
  logic [POLL_W-1:0]  poll_q;

  logic               tmr_load, tmr_exp;
  logic [TMR_W-1:0]   tmr_val;
  logic               rp_go, rp_we, rp_done, link_up, reg_state;
  logic [ADDR_W-1:0]  rp_addr;
  logic [DATA_W-1:0]  rp_wdata, rp_rdata, dt_code;

  assign dt_code = mode_q ? DT_RC : DT_EP;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(RST_WAIT_MS);
    unique case (state_q)
      ST_IDLE:   tmr_load = start_i;
      ST_W_SLOT: tmr_load = tmr_exp;
      ST_W_PWR:  tmr_load = tmr_exp;
      ST_LTSSM: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRAIN_WAIT_MS);
      end
      default: ;
    endcase
  end

  always_comb begin
    reg_state = 1'b1;
    rp_we     = 1'b0;
    rp_addr   = ADDR_W'(DEVTYPE_ADDR);
    rp_wdata  = '0;
    unique case (state_q)
      ST_DT_WR: begin
        rp_we    = 1'b1;
        rp_wdata = dt_code;
      end
      ST_DT_RD:   ;
      ST_MISC_RD: rp_addr = ADDR_W'(MISC_ADDR);
      ST_MISC_SET: begin
        rp_we    = 1'b1;
        rp_addr  = ADDR_W'(MISC_ADDR);
        rp_wdata = misc_q | RO_MASK;
      end
      ST_CAP_RD:  rp_addr = ADDR_W'(LINKCAP_ADDR);
      ST_CAP_WR: begin
        rp_we    = 1'b1;
        rp_addr  = ADDR_W'(LINKCAP_ADDR);
        rp_wdata = cap_q | SPEED_MASK;
      end
      ST_MISC_CLR: begin
        rp_we    = 1'b1;
        rp_addr  = ADDR_W'(MISC_ADDR);
        rp_wdata = misc_q & ~RO_MASK;
      end
      default: reg_state = 1'b0;
    endcase
    rp_go = reg_state && !pend_q;
  end

  bup_tick_timer #(.CNT_W(TMR_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .tick_i    (ms_tick_i),
    .expired_o (tmr_exp)
  );

  bup_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_reg_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (rp_go),
    .we_i    (rp_we),
    .addr_i  (rp_addr),
    .wdata_i (rp_wdata),
    .req_o   (reg_req_o),
    .we_o    (reg_we_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .ack_i   (reg_ack_i),
    .rdata_i (reg_rdata_i),
    .done_o  (rp_done),
    .rdata_o (rp_rdata)
  );

  bup_link_eval #(.DATA_W(DATA_W), .UP_BIT(UP_BIT), .TRAIN_BIT(TRAIN_BIT)) i_link_eval (
    .status_i (link_status_i),
    .up_o     (link_up)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_q   <= 1'b0;
      pwr_q    <= 1'b0;
      aux_q    <= 1'b0;
      ctrl_q   <= 1'b0;
      hold_q   <= 1'b0;
      ltssm_q  <= 1'b0;
      pstart_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      mode_q   <= 1'b0;
      pend_q   <= 1'b0;
      res_q    <= RES_OK;
      misc_q   <= '0;
      cap_q    <= '0;
      poll_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      pstart_q <= 1'b0;
      if (reg_state) begin
        if (!pend_q) pend_q <= 1'b1;
        else if (rp_done) pend_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          busy_q  <= 1'b1;
          mode_q  <= mode_rc_i;
          slot_q  <= 1'b0;
          pwr_q   <= 1'b0;
          aux_q   <= 1'b0;
          ctrl_q  <= 1'b0;
          hold_q  <= 1'b0;
          ltssm_q <= 1'b0;
          state_q <= ST_W_SLOT;
        end
        ST_W_SLOT: if (tmr_exp) begin
          pwr_q   <= 1'b1;
          state_q <= ST_W_PWR;
        end
        ST_W_PWR: if (tmr_exp) begin
          slot_q  <= 1'b1;
          state_q <= ST_W_REL;
        end
        ST_W_REL: if (tmr_exp) begin
          aux_q   <= 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          hold_q  <= 1'b1;
          state_q <= ST_CTRL;
        end
        ST_CTRL: begin
          ctrl_q   <= 1'b1;
          pstart_q <= 1'b1;
          state_q  <= ST_PROG;
        end
        ST_PROG: if (phy_prog_done_i) begin
          aux_q   <= 1'b0;
          state_q <= ST_HOLD_REL;
        end
        ST_HOLD_REL: begin
          hold_q  <= 1'b0;
          state_q <= ST_AUX_ON;
        end
        ST_AUX_ON: begin
          aux_q   <= 1'b1;
          state_q <= ST_DT_WR;
        end
        ST_DT_WR: if (pend_q && rp_done) state_q <= ST_DT_RD;
        ST_DT_RD: if (pend_q && rp_done) begin
          if (rp_rdata != dt_code) begin
            res_q   <= RES_MISMATCH;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_LNK0;
          end
        end
        ST_LNK0: begin
          if (link_up) begin
            res_q   <= RES_ALREADY;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_MISC_RD;
          end
        end
        ST_MISC_RD: if (pend_q && rp_done) begin
          misc_q  <= rp_rdata;
          state_q <= ST_MISC_SET;
        end
        ST_MISC_SET: if (pend_q && rp_done) state_q <= ST_CAP_RD;
        ST_CAP_RD: if (pend_q && rp_done) begin
          cap_q   <= rp_rdata;
          state_q <= ST_CAP_WR;
        end
        ST_CAP_WR:   if (pend_q && rp_done) state_q <= ST_MISC_CLR;
        ST_MISC_CLR: if (pend_q && rp_done) state_q <= ST_LTSSM;
        ST_LTSSM: begin
          ltssm_q <= 1'b1;
          state_q <= ST_W_TRAIN;
        end
        ST_W_TRAIN: if (tmr_exp) begin
          poll_q  <= '0;
          state_q <= ST_POLL;
        end
        ST_POLL: if (ms_tick_i) begin
          if (link_up) begin
            res_q   <= RES_OK;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
            hold_q  <= 1'b1;
            res_q   <= RES_TIMEOUT;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_rst_no      = slot_q;
  assign pwr_en_o         = pwr_q;
  assign aux_clk_en_o     = aux_q;
  assign ctrl_rst_no      = ctrl_q;
  assign phy_hold_rst_o   = hold_q;
  assign ltssm_en_o       = ltssm_q;
  assign phy_prog_start_o = pstart_q;
  assign busy_o           = busy_q;
  assign done_o           = done_q;
  assign result_o         = res_q;
endmodule

// File: rtl/pcie_port_bringup_chk.sv
module pcie_port_bringup_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_rst_no,
  input logic              pwr_en_o,
  input logic              aux_clk_en_o,
  input logic              ctrl_rst_no,
  input logic              phy_hold_rst_o,
  input logic              ltssm_en_o,
  input logic              phy_prog_start_o,
  input logic              reg_req_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o
);
  AST_PWR_UNDER_SLOT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> !slot_rst_no); // R2
  AST_HOLD_BEFORE_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_rst_no) |-> phy_hold_rst_o && aux_clk_en_o); // R3
  AST_PROG_UNDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_prog_start_o |-> phy_hold_rst_o && ctrl_rst_no && !ltssm_en_o); // R3
  AST_HOLD_REL_AUX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_hold_rst_o) |-> !aux_clk_en_o); // R4
  AST_EARLY_END_NO_LTSSM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (result_o == 2'd1 || result_o == 2'd2) |-> !ltssm_en_o); // R6
  AST_LTSSM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ltssm_en_o) |-> !phy_hold_rst_o && aux_clk_en_o && ctrl_rst_no && slot_rst_no); // R8
  AST_TIMEOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o == 2'd3 |-> phy_hold_rst_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o) && $stable(reg_wdata_o)); // R12
endmodule

bind pcie_port_bringup pcie_port_bringup_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .slot_rst_no      (slot_rst_no),
  .pwr_en_o         (pwr_en_o),
  .aux_clk_en_o     (aux_clk_en_o),
  .ctrl_rst_no      (ctrl_rst_no),
  .phy_hold_rst_o   (phy_hold_rst_o),
  .ltssm_en_o       (ltssm_en_o),
  .phy_prog_start_o (phy_prog_start_o),
  .reg_req_o        (reg_req_o),
  .reg_we_o         (reg_we_o),
  .reg_addr_o       (reg_addr_o),
  .reg_wdata_o      (reg_wdata_o),
  .reg_ack_i        (reg_ack_i),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .result_o         (result_o)
);

// File: tb/test_pcie_port_bringup.sv
module test_pcie_port_bringup;
  localparam logic [11:0] A_DT   = 12'h708;
  localparam logic [11:0] A_MISC = 12'h8BC;
  localparam logic [11:0] A_CAP  = 12'h07C;
  localparam logic [31:0] MISC_INIT = 32'h0000_5A50;
  localparam logic [31:0] CAP_INIT  = 32'h0047_3C12;
  // {mode_rc, bad_devtype, link_mode[1:0], expected_result[1:0]}
  // link_mode: 0 never up, 1 up from start, 2 up 25 ticks after ltssm, 3 up but training
  localparam logic [5:0] CASES [6] = '{
    6'b1_0_10_00, 6'b0_0_10_00, 6'b1_1_10_10,
    6'b1_0_01_01, 6'b1_0_00_11, 6'b0_0_11_11
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_rc = 1'b0, tick = 1'b0;
  logic phy_done = 1'b0, ack = 1'b0;
  logic [31:0] rdata = '0, lstat = '0;
  logic slot_n, pwr, aux, ctrl_n, hold, ltssm, pstart, req, we, busy, done;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [1:0] result;

  int checks = 0, errors = 0;
  int cyc = 0, tdiv = 0;
  int n_w1, n_w2, n_w3, n_lt, n_done, n_wr, wr_at_lt, r12_bad, aux_rises;
  int t_aux1, t_hold1, t_ctrl, t_pst, t_pdone, t_auxf, t_holdf, t_aux2;
  int pcnt = 0, stall = 0;
  bit pend = 0, bad_dt = 0, sw = 0;
  int lmode = 0;
  logic [11:0] sa;
  logic [31:0] sd, dt_r, misc_r, cap_r;
  logic [11:0] w_addr [16];
  logic [31:0] w_data [16];
  logic slot_p = 0, pwr_p = 0, aux_p = 0, ctrl_p = 0, hold_p = 0, lt_p = 0, busy_p = 0;

  always #10 clk = ~clk;

  pcie_port_bringup i_pcie_port_bringup (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_rc_i(mode_rc), .ms_tick_i(tick),
    .slot_rst_no(slot_n), .pwr_en_o(pwr), .aux_clk_en_o(aux), .ctrl_rst_no(ctrl_n),
    .phy_hold_rst_o(hold), .ltssm_en_o(ltssm), .phy_prog_start_o(pstart),
    .phy_prog_done_i(phy_done), .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_ack_i(ack), .reg_rdata_i(rdata), .link_status_i(lstat),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // monitor, tick source, register model, PHY programming model
  always @(negedge clk) begin
    cyc++;
    if (tick && busy_p) begin
      if (!pwr_p) n_w1++;
      else if (!slot_p) n_w2++;
      else if (!ctrl_p && !aux_p) n_w3++;
      if (lt_p) n_lt++;
    end
    if (!aux_p && aux) begin
      if (aux_rises == 0) t_aux1 = cyc; else t_aux2 = cyc;
      aux_rises++;
    end
    if (aux_p && !aux) t_auxf = cyc;
    if (!hold_p && hold && t_hold1 < 0) t_hold1 = cyc;
    if (hold_p && !hold) t_holdf = cyc;
    if (!ctrl_p && ctrl_n) t_ctrl = cyc;
    if (pstart) t_pst = cyc;
    if (!lt_p && ltssm) wr_at_lt = n_wr;
    if (done) n_done++;
    slot_p = slot_n; pwr_p = pwr; aux_p = aux; ctrl_p = ctrl_n;
    hold_p = hold; lt_p = ltssm; busy_p = busy;
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 3);
    case (lmode)
      1: lstat = 32'h0000_0010;
      2: lstat = (n_lt >= 25) ? 32'h0000_0010 : 32'h0;
      3: lstat = 32'h2000_0010;
      default: lstat = 32'h0;
    endcase
    phy_done = 1'b0;
    if (pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) begin phy_done = 1'b1; t_pdone = cyc; end
    end
    if (pstart) pcnt = 5;
    if (ack) begin
      ack = 1'b0;
      pend = 0;
    end else if (req) begin
      if (!pend) begin
        pend = 1; stall = 2; sa = addr; sw = we; sd = wdata;
      end else if (addr != sa || we != sw || wdata != sd) begin
        r12_bad++;
      end
      if (stall == 0) begin
        ack = 1'b1;
        if (sw) begin
          if (n_wr < 16) begin w_addr[n_wr] = sa; w_data[n_wr] = sd; end
          n_wr++;
          if (sa == A_DT) dt_r = sd;
          else if (sa == A_MISC) misc_r = sd;
          else if (sa == A_CAP && misc_r[0]) cap_r = sd;
        end else begin
          if (sa == A_DT) rdata = bad_dt ? 32'h7 : dt_r;
          else if (sa == A_MISC) rdata = misc_r;
          else if (sa == A_CAP) rdata = cap_r;
          else rdata = 32'hDEAD_0000;
        end
      end else begin
        stall--;
      end
    end
  end

  task automatic run_case(input int idx, input bit poke);
    logic [5:0] c;
    logic [1:0] exp_res;
    c = CASES[idx];
    exp_res = c[1:0];
    @(negedge clk); #1;
    n_w1 = 0; n_w2 = 0; n_w3 = 0; n_lt = 0; n_done = 0; n_wr = 0; wr_at_lt = -1;
    r12_bad = 0; aux_rises = 0;
    t_aux1 = -1; t_hold1 = -1; t_ctrl = -1; t_pst = -1; t_pdone = -1;
    t_auxf = -1; t_holdf = -1; t_aux2 = -1;
    dt_r = 32'hFFFF_FFFF; misc_r = MISC_INIT; cap_r = CAP_INIT;
    bad_dt = c[4]; lmode = int'(c[3:2]); mode_rc = c[5];
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    mode_rc = ~c[5];
    if (poke) begin
      do begin @(negedge clk); #1; end while (n_w2 < 30);
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      @(negedge clk); #1;
      chk(pwr == 1'b1 && slot_n == 1'b0 && busy == 1'b1, "R11", "start while busy restarted run",
          {29'd0, busy, slot_n, pwr}, 32'h5);
    end
    do begin @(negedge clk); #1; end while (n_done == 0);
    repeat (3) @(negedge clk);
    #1;
    chk(result == exp_res, "R5/R6/R8/R9", $sformatf("case %0d result", idx), result, exp_res);
    chk(n_done == 1 && busy == 1'b0, "R10", "single done pulse and idle", n_done, 1);
    chk(n_w1 == 100, "R2", "ticks before power enable", n_w1, 100);
    chk(n_w2 == 100, "R2", "ticks before slot reset release", n_w2, 100);
    chk(n_w3 == 100, "R2", "ticks before aux clock enable", n_w3, 100);
    chk(t_hold1 == t_aux1 + 1 && t_ctrl == t_hold1 + 1 && t_pst == t_ctrl, "R3",
        "aux/hold/ctrl/prog order", t_ctrl - t_aux1, 2);
    chk(t_auxf == t_pdone + 1 && t_holdf == t_auxf + 1 && t_aux2 == t_holdf + 1, "R4",
        "aux off / hold release / aux on", t_aux2 - t_pdone, 3);
    chk(n_wr >= 1 && w_addr[0] == A_DT && w_data[0] == (c[5] ? 32'h4 : 32'h0), "R5",
        "device type write", w_data[0], c[5] ? 32'h4 : 32'h0);
    chk(r12_bad == 0, "R12", "request fields moved before ack", r12_bad, 0);
    if (exp_res == 2'd1 || exp_res == 2'd2) begin
      chk(n_wr == 1 && ltssm == 1'b0, "R6", "early end made writes or enabled ltssm",
          n_wr, 1);
    end else begin
      chk(n_wr == 4 && wr_at_lt == 4, "R7", "writes before ltssm", wr_at_lt, 4);
      chk(w_addr[1] == A_MISC && w_data[1] == (MISC_INIT | 32'h1), "R7", "window open write",
          w_data[1], MISC_INIT | 32'h1);
      chk(w_addr[2] == A_CAP && cap_r == (CAP_INIT | 32'hF), "R7", "link cap value",
          cap_r, CAP_INIT | 32'hF);
      chk(w_addr[3] == A_MISC && misc_r == MISC_INIT, "R7", "window close write",
          misc_r, MISC_INIT);
    end
    if (exp_res == 2'd0) begin
      chk(ltssm == 1'b1 && hold == 1'b0 && n_lt == 26, "R8", "ticks to trained link",
          n_lt, 26);
    end
    if (exp_res == 2'd3) begin
      chk(hold == 1'b1 && n_lt == 40, "R9", "timeout ticks with hold reasserted", n_lt, 40);
      repeat (40) @(negedge clk);
      #1;
      chk(result == 2'd3 && done == 1'b0, "R10", "result held after done", result, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({slot_n, pwr, aux, ctrl_n, hold, ltssm, busy, done, req} == 9'b0, "R1",
        "outputs in reset", {23'd0, slot_n, pwr, aux, ctrl_n, hold, ltssm, busy, done, req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({slot_n, pwr, aux, ctrl_n, hold, ltssm, busy, done, req} == 9'b0, "R1",
        "outputs after reset release", {23'd0, slot_n, pwr, aux, ctrl_n, hold, ltssm, busy, done, req}, 0);
    for (int i = 0; i < 6; i++) run_case(i, i == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule